// File: doc/BRIEF.md
# Secured-Bus Slave Integrity Verifier

This block sits at the receiving end of a secured point-to-multipoint bus. A master first puts a 16-bit select value on the bus. The slave compares it with its own identity and acknowledges only when the two are equal. The master then sends two words, a 16-bit encrypted result and a 16-bit digest. The slave decrypts the result with a local 16-bit Feistel decryption engine that completes one round per clock. It then rebuilds the digest from its identity, the shared key and the recovered plaintext.

If the rebuilt digest equals the received one, the slave returns a positive verdict and presents the plaintext on a valid-qualified output. If it differs, the slave returns a negative verdict, drops the plaintext and increments a mismatch counter. In both cases the verdict carries the slave's identity as a tag. The key and the identity are static inputs. Every bus word is qualified by a single-cycle strobe, and the slave handles one transaction at a time.

Top module: `slv_verifier`

## Requirements
- R1: `ack_sel` pulses high for exactly one cycle, in the cycle after an edge that samples `sel_valid`=1 with `sel_value` equal to `self_id` while the block is idle. A select value that is not equal to `self_id` gives no acknowledgement and starts no transaction.
- R2: The ciphertext is decrypted with the inverse of this 32-round cipher. The block is split into halves, hi=bits[15:8] and lo=bits[7:0]. The key is split into k0=key[7:0], k1=key[15:8], k2=key[23:16] and k3=key[31:24]. F(x,a,b,s)=((x<<1)+a)^(x+s)^((x>>2)+b), computed modulo 256. Each encryption round does s+=0x9E, then hi+=F(lo,k0,k1,s), then lo+=F(hi,k2,k3,s). The value s starts at 0.
- R3: The expected digest is rotl16(`self_id` ^ key[15:0], 3) + (plaintext ^ key[31:16]), computed modulo 2^16. A transaction passes only when this value equals the received digest.
- R4: Each accepted transaction gives exactly one `verdict_valid` pulse of one cycle. `verdict_ok` is 1 on a pass and 0 on a fail, and `verdict_tag` equals `self_id`. Count the edge that samples the later of the two data strobes as edge 1. The pulse is then visible after edge 34.
- R5: On a pass, `result_valid` is high in the verdict cycle and `result_data` holds the decrypted plaintext.
- R6: On a fail, `result_valid` stays low, `result_data` keeps its previous value, and `mismatch_count` increments by one (wrapping) in the verdict cycle. The count is unchanged on a pass.
- R7: Ciphertext or digest strobes that are not preceded by an acknowledged select are ignored: they produce no verdict and no result.
- R8: Selects that arrive between an acknowledgement and its verdict, including ones matching `self_id`, are ignored and produce no `ack_sel`.
- R9: The ciphertext and the digest may arrive in either order or in the same cycle. Within one transaction only the first strobe of each kind is kept.
- R10: After reset, `ack_sel`, `verdict_valid`, `verdict_ok`, `result_valid`, `result_data`, `verdict_tag` and `mismatch_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key | input | 32 | Static shared key |
| self_id | input | 16 | Static identity of this slave |
| sel_valid | input | 1 | Select strobe |
| sel_value | input | 16 | Select value on the bus |
| ct_valid | input | 1 | Ciphertext strobe |
| ct_data | input | 16 | Encrypted result |
| dg_valid | input | 1 | Digest strobe |
| dg_data | input | 16 | Received digest |
| ack_sel | output | 1 | Select acknowledgement pulse |
| verdict_valid | output | 1 | Verdict pulse |
| verdict_ok | output | 1 | 1 = digest matched, 0 = mismatch |
| verdict_tag | output | 16 | Identity returned with the verdict |
| result_valid | output | 1 | Plaintext valid pulse |
| result_data | output | 16 | Decrypted plaintext |
| mismatch_count | output | CNT_W | Wrapping count of failed checks |

## Verification
The hardest case to reach from the ports is a matching select that arrives while the block is still decrypting. That select is legal on the bus, yet it must be ignored. The bench reaches it by issuing a select for `self_id` in the middle of the 32-round decryption window. It then checks that no acknowledgement appears, that the original verdict still arrives on time, and that no second verdict follows. Repeated strobes inside the waiting window and strobes with no prior select are driven the same way, and the bench watches the outputs for stray pulses.

// File: rtl/svr_pkg.sv
package svr_pkg;

  localparam int BLK_W  = 16;
  localparam int HALF_W = BLK_W / 2;
  localparam int KEY_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DEC  = 2'd2
  } txn_st_t;

  // round mixing function on one half
  function automatic logic [HALF_W-1:0] mix_f(
    input logic [HALF_W-1:0] x,
    input logic [HALF_W-1:0] ka,
    input logic [HALF_W-1:0] kb,
    input logic [HALF_W-1:0] s
  );
    return ((x << 1) + ka) ^ (x + s) ^ ((x >> 2) + kb);
  endfunction

  // one inverse round: undo lo first, then hi
  function automatic logic [BLK_W-1:0] dec_round(
    input logic [BLK_W-1:0]  blk,
    input logic [KEY_W-1:0]  key,
    input logic [HALF_W-1:0] s
  );
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
    hi = blk[BLK_W-1:HALF_W];
    lo = blk[HALF_W-1:0];
    lo = lo - mix_f(hi, key[23:16], key[31:24], s);
    hi = hi - mix_f(lo, key[7:0],   key[15:8],  s);
    return {hi, lo};
  endfunction

  // digest over identity, key and plaintext
  function automatic logic [BLK_W-1:0] digest_f(
    input logic [BLK_W-1:0] sel,
    input logic [BLK_W-1:0] pt,
    input logic [KEY_W-1:0] key
  );
    logic [BLK_W-1:0] a;
    a = sel ^ key[15:0];
    return {a[12:0], a[15:13]} + (pt ^ key[31:16]);
  endfunction

endpackage

// File: rtl/svr_dec_engine.sv
module svr_dec_engine
  import svr_pkg::*;
#(
  parameter int ROUNDS = 32,
  parameter int DELTA  = 8'h9E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BLK_W-1:0]     ct_in,
  input  logic [KEY_W-1:0]     key,
  output logic [BLK_W-1:0]     pt_out,
  output logic                 done
);

  localparam int RC_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [HALF_W-1:0] D8    = HALF_W'(DELTA);
  localparam logic [HALF_W-1:0] SUM0  = HALF_W'(ROUNDS * DELTA);
  localparam logic [RC_W-1:0]   LAST  = RC_W'(ROUNDS - 1);

  logic [BLK_W-1:0]  blk_q;
  logic [HALF_W-1:0] sum_q;
  logic [RC_W-1:0]   rcnt_q;
  logic              run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      sum_q  <= '0;
      rcnt_q <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      blk_q  <= ct_in;
      sum_q  <= SUM0;
      rcnt_q <= '0;
      run_q  <= 1'b1;
      done   <= 1'b0;
    end else if (run_q) begin
      blk_q  <= dec_round(blk_q, key, sum_q);
      sum_q  <= sum_q - D8;
      rcnt_q <= rcnt_q + 1'b1;
      done   <= (rcnt_q == LAST);
      if (rcnt_q == LAST) run_q <= 1'b0;
    end else begin
      done   <= 1'b0;
    end
  end

  assign pt_out = blk_q;

endmodule

// File: rtl/svr_txn_ctrl.sv
module svr_txn_ctrl
  import svr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  self_id,
  input  logic              sel_valid,
  input  logic [BLK_W-1:0]  sel_value,
  input  logic              ct_valid,
  input  logic [BLK_W-1:0]  ct_data,
  input  logic              dg_valid,
  input  logic [BLK_W-1:0]  dg_data,
  input  logic              eng_done,
  output logic              ack,
  output logic              sel_hit,
  output logic              busy,
  output logic              eng_start,
  output logic [BLK_W-1:0]  ct_word,
  output logic [BLK_W-1:0]  dg_word,
  output logic              fire
);

  txn_st_t          st_q;
  logic             have_ct_q;
  logic             have_dg_q;
  logic [BLK_W-1:0] ct_hold_q;

  assign sel_hit   = sel_valid && (sel_value == self_id);
  assign busy      = (st_q != ST_IDLE);
  assign eng_start = (st_q == ST_WAIT) && (have_ct_q || ct_valid) && (have_dg_q || dg_valid);
  assign ct_word   = have_ct_q ? ct_hold_q : ct_data;
  assign fire      = (st_q == ST_DEC) && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      have_ct_q <= 1'b0;
      have_dg_q <= 1'b0;
      ct_hold_q <= '0;
      dg_word   <= '0;
      ack       <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (sel_hit) begin
            ack       <= 1'b1;
            have_ct_q <= 1'b0;
            have_dg_q <= 1'b0;
            st_q      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ct_valid && !have_ct_q) begin
            ct_hold_q <= ct_data;
            have_ct_q <= 1'b1;
          end
          if (dg_valid && !have_dg_q) begin
            dg_word   <= dg_data;
            have_dg_q <= 1'b1;
          end
          if (eng_start) st_q <= ST_DEC;
        end
        ST_DEC: begin
          if (eng_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/slv_verifier.sv
module slv_verifier
  import svr_pkg::*;
#(
  parameter int ROUNDS = 32,
  parameter int DELTA  = 8'h9E,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       key,
  input  logic [15:0]       self_id,
  input  logic              sel_valid,
  input  logic [15:0]       sel_value,
  input  logic              ct_valid,
  input  logic [15:0]       ct_data,
  input  logic              dg_valid,
  input  logic [15:0]       dg_data,
  output logic              ack_sel,
  output logic              verdict_valid,
  output logic              verdict_ok,
  output logic [15:0]       verdict_tag,
  output logic              result_valid,
  output logic [15:0]       result_data,
  output logic [CNT_W-1:0]  mismatch_count
);

  logic             sel_hit;
  logic             busy;
  logic             eng_start;
  logic             eng_done;
  logic             fire;
  logic [BLK_W-1:0] ct_word;
  logic [BLK_W-1:0] dg_word;
  logic [BLK_W-1:0] pt_word;
  logic [BLK_W-1:0] dg_expect;
  logic             dg_match;

  svr_txn_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .self_id   (self_id),
    .sel_valid (sel_valid),
    .sel_value (sel_value),
    .ct_valid  (ct_valid),
    .ct_data   (ct_data),
    .dg_valid  (dg_valid),
    .dg_data   (dg_data),
    .eng_done  (eng_done),
    .ack       (ack_sel),
    .sel_hit   (sel_hit),
    .busy      (busy),
    .eng_start (eng_start),
    .ct_word   (ct_word),
    .dg_word   (dg_word),
    .fire      (fire)
  );

  svr_dec_engine #(.ROUNDS(ROUNDS), .DELTA(DELTA)) i_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .ct_in  (ct_word),
    .key    (key),
    .pt_out (pt_word),
    .done   (eng_done)
  );

  assign dg_expect = digest_f(self_id, pt_word, key);
  assign dg_match  = (dg_expect == dg_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_ok     <= 1'b0;
      verdict_tag    <= '0;
      result_valid   <= 1'b0;
      result_data    <= '0;
      mismatch_count <= '0;
    end else begin
      verdict_valid <= fire;
      result_valid  <= fire && dg_match;
      if (fire) begin
        verdict_ok  <= dg_match;
        verdict_tag <= self_id;
        if (dg_match) result_data    <= pt_word;
        else          mismatch_count <= mismatch_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      self_id,
  input logic             sel_hit,
  input logic             busy,
  input logic             ack_sel,
  input logic             verdict_valid,
  input logic             verdict_ok,
  input logic [15:0]      verdict_tag,
  input logic             result_valid,
  input logic [CNT_W-1:0] mismatch_count
);

  AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_sel |-> $past(sel_hit && !busy)); // R1

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ack_sel); // R8

  AST_VERDICT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (verdict_tag == self_id)); // R4

  AST_VERDICT_FROM_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(busy)); // R7

  AST_RESULT_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (verdict_valid && verdict_ok)); // R5

  AST_MISS_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !verdict_ok) |-> (mismatch_count == CNT_W'($past(mismatch_count) + 1'b1))); // R6

  AST_MISS_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict_valid && !verdict_ok) |-> $stable(mismatch_count)); // R6

endmodule

bind slv_verifier svr_checker #(.CNT_W(CNT_W)) i_svr_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .self_id        (self_id),
  .sel_hit        (sel_hit),
  .busy           (busy),
  .ack_sel        (ack_sel),
  .verdict_valid  (verdict_valid),
  .verdict_ok     (verdict_ok),
  .verdict_tag    (verdict_tag),
  .result_valid   (result_valid),
  .mismatch_count (mismatch_count)
);

// File: tb/test_slv_verifier.sv
`timescale 1ns/1ps
module test_slv_verifier;

  localparam logic [31:0] KEY = 32'hA5C3_1E77;
  localparam logic [15:0] ME  = 16'h0042;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_valid = 1'b0;
  logic [15:0] sel_value = '0;
  logic        ct_valid = 1'b0;
  logic [15:0] ct_data = '0;
  logic        dg_valid = 1'b0;
  logic [15:0] dg_data = '0;
  logic        ack_sel, verdict_valid, verdict_ok, result_valid;
  logic [15:0] verdict_tag, result_data;
  logic [7:0]  mismatch_count;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] cnt_ref = '0;
  logic [15:0] res_ref = '0;

  always #2.5 clk = ~clk;

  slv_verifier i_slv_verifier (
    .clk(clk), .rst_n(rst_n), .key(KEY), .self_id(ME),
    .sel_valid(sel_valid), .sel_value(sel_value),
    .ct_valid(ct_valid), .ct_data(ct_data),
    .dg_valid(dg_valid), .dg_data(dg_data),
    .ack_sel(ack_sel), .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .verdict_tag(verdict_tag), .result_valid(result_valid),
    .result_data(result_data), .mismatch_count(mismatch_count)
  );

  function automatic logic [7:0] ff(input logic [7:0] x, input logic [7:0] a,
                                    input logic [7:0] b, input logic [7:0] s);
    logic [7:0] t1, t2, t3;
    t1 = {x[6:0], 1'b0} + a;
    t2 = x + s;
    t3 = {2'b00, x[7:2]} + b;
    return t1 ^ t2 ^ t3;
  endfunction

  function automatic logic [15:0] encrypt(input logic [15:0] p);
    logic [7:0] hi, lo, s;
    hi = p[15:8]; lo = p[7:0]; s = 8'h00;
    for (int i = 0; i < 32; i++) begin
      s  = s + 8'h9E;
      hi = hi + ff(lo, KEY[7:0], KEY[15:8], s);
      lo = lo + ff(hi, KEY[23:16], KEY[31:24], s);
    end
    return {hi, lo};
  endfunction

  function automatic logic [15:0] digest(input logic [15:0] p);
    logic [31:0] dbl;
    dbl = {ME ^ KEY[15:0], ME ^ KEY[15:0]};
    return dbl[28:13] + (p ^ KEY[31:16]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_select(input logic [15:0] id, input bit expect_ack);
    @(negedge clk);
    sel_valid = 1'b1; sel_value = id;
    @(negedge clk);
    sel_valid = 1'b0;
    chk(ack_sel == expect_ack, "R1 ack", 32'(ack_sel), 32'(expect_ack));
    @(negedge clk);
    chk(ack_sel == 1'b0, "R1 ack width", 32'(ack_sel), 0);
  endtask

  // order: 0 same cycle, 1 ciphertext first, 2 digest first
  task automatic send(input logic [15:0] ct, input logic [15:0] dg, input int order);
    @(negedge clk);
    if (order == 2) begin
      dg_valid = 1'b1; dg_data = dg;
      @(negedge clk);
      dg_valid = 1'b0;
      ct_valid = 1'b1; ct_data = ct;
    end else if (order == 1) begin
      ct_valid = 1'b1; ct_data = ct;
      @(negedge clk);
      ct_valid = 1'b0;
      dg_valid = 1'b1; dg_data = dg;
    end else begin
      ct_valid = 1'b1; ct_data = ct;
      dg_valid = 1'b1; dg_data = dg;
    end
  endtask

  task automatic wait_verdict(output int lat);
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      ct_valid = 1'b0; dg_valid = 1'b0;
      lat++;
      if (verdict_valid) break;
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ct_valid = 1'b0; dg_valid = 1'b0; sel_valid = 1'b0;
      if (verdict_valid || result_valid || ack_sel) seen = 1'b1;
    end
    chk(!seen, req, 32'(seen), 0);
  endtask

  task automatic t_reset();
    chk(!ack_sel && !verdict_valid && !verdict_ok && !result_valid, "R10 flags",
        {28'd0, ack_sel, verdict_valid, verdict_ok, result_valid}, 0);
    chk(result_data == 0 && verdict_tag == 0 && mismatch_count == 0, "R10 data",
        {result_data, verdict_tag}, 0);
  endtask

  task automatic t_pass(input logic [15:0] pt, input int order);
    int lat;
    do_select(ME, 1'b1);
    send(encrypt(pt), digest(pt), order);
    wait_verdict(lat);
    chk(lat == 34, "R4 latency", 32'(lat), 34);
    chk(verdict_valid && verdict_ok, "R3 pass verdict", 32'(verdict_ok), 1);
    chk(verdict_tag == ME, "R4 tag", 32'(verdict_tag), 32'(ME));
    chk(result_valid && result_data == pt, "R2 R5 plaintext", 32'(result_data), 32'(pt));
    chk(mismatch_count == cnt_ref, "R6 count on pass", 32'(mismatch_count), 32'(cnt_ref));
    res_ref = pt;
    @(negedge clk);
    chk(!verdict_valid && !result_valid, "R4 single pulse", 32'(verdict_valid), 0);
  endtask

  task automatic t_fail(input logic [15:0] pt);
    int lat;
    do_select(ME, 1'b1);
    send(encrypt(pt), digest(pt) ^ 16'h0100, 0);
    wait_verdict(lat);
    cnt_ref = cnt_ref + 1'b1;
    chk(verdict_valid && !verdict_ok, "R3 fail verdict", 32'(verdict_ok), 0);
    chk(!result_valid, "R6 no result", 32'(result_valid), 0);
    chk(result_data == res_ref, "R6 result held", 32'(result_data), 32'(res_ref));
    chk(mismatch_count == cnt_ref, "R6 count up", 32'(mismatch_count), 32'(cnt_ref));
  endtask

  task automatic t_wrong_select();
    do_select(ME ^ 16'h0001, 1'b0);
    send(encrypt(16'h1234), digest(16'h1234), 0);
    expect_quiet(45, "R1 R7 no txn after foreign select");
  endtask

  task automatic t_stray();
    send(encrypt(16'h5555), digest(16'h5555), 1);
    expect_quiet(45, "R7 stray strobes");
  endtask

  task automatic t_busy_select(input logic [15:0] pt);
    int lat;
    do_select(ME, 1'b1);
    send(encrypt(pt), digest(pt), 0);
    repeat (10) @(negedge clk);
    ct_valid = 1'b0; dg_valid = 1'b0;
    sel_valid = 1'b1; sel_value = ME;
    @(negedge clk);
    sel_valid = 1'b0;
    chk(!ack_sel, "R8 no ack while busy", 32'(ack_sel), 0);
    wait_verdict(lat);
    chk(lat == 23 && verdict_ok && result_data == pt, "R8 verdict intact", 32'(result_data), 32'(pt));
    res_ref = pt;
    send(encrypt(16'h0F0F), digest(16'h0F0F), 0);
    expect_quiet(45, "R8 busy select left no txn");
  endtask

  task automatic t_duplicate(input logic [15:0] pt);
    int lat;
    do_select(ME, 1'b1);
    @(negedge clk);
    ct_valid = 1'b1; ct_data = encrypt(pt);
    @(negedge clk);
    ct_data = encrypt(pt ^ 16'hFFFF);
    @(negedge clk);
    ct_valid = 1'b0;
    dg_valid = 1'b1; dg_data = digest(pt);
    wait_verdict(lat);
    chk(verdict_ok && result_data == pt, "R9 first ciphertext kept", 32'(result_data), 32'(pt));
    res_ref = pt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pass(16'h0011, 0);
    t_pass(16'hBEEF, 1);
    t_pass(16'h0000, 2);
    t_pass(16'hFFFF, 0);
    t_fail(16'h7A3C);
    t_fail(16'h0001);
    t_wrong_select();
    t_stray();
    t_busy_select(16'hC0DE);
    t_duplicate(16'h2468);
    t_pass(16'h8001, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule